// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control state machine of a multicycle datapath. It receives the type field of the instruction held in the instruction register, a wait flag from memory and the zero flag from the ALU. On every cycle it drives one group of control strobes to the datapath: PC source and PC write enable, instruction-register capture, memory read and write, memory address source, register-operand read, ALU operation, register-file write and write-back source. Every choice among several sources is a one-hot vector. A strobe that has no use in a state is held at 0.

All instructions share the first two states, fetch and decode. After decode, each instruction class follows its own chain of states, and the class is part of the state code. Ten states exist, so the state code is four bits wide. The short chains (jump and branch) go back to fetch early. A load has the longest chain: fetch, decode, address computation, memory read, write-back. Each state that accesses memory stays where it is while the wait flag is high, so memory may take any number of cycles to respond. The state code is brought out on a port so that the datapath and the tests can follow the sequence.

Top module: `mc_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the state at 0 (fetch), even when it is applied in the middle of an instruction.
- R2: In state 0 the block asserts `mem_rd`, `alu_sel`=001 (add) and `pc_src`=001 (PC+1). `ir_latch` and `pc_load` are high only while `mem_wait` is low, and state 1 follows when `mem_wait` is low.
- R3: In state 1 only `reg_rd` is high. The next state depends on `instr_type`: 0 (ALU op) goes to 6, 1 (load) and 2 (store) go to 2, 3 (branch) goes to 8, 4 (jump) goes to 9, and codes 5 to 7 go back to 0.
- R4: A load passes through states 2, 3, 4 and then returns to 0. State 2 drives `alu_sel`=001. State 3 drives `mem_rd` and `addr_sel`. State 4 drives `reg_wr` with `wb_src`=10 (memory data).
- R5: A store passes through states 2 and 5 and then returns to 0. State 5 drives `mem_wr` and `addr_sel`.
- R6: An ALU op passes through states 6 and 7 and then returns to 0. State 6 drives `alu_sel`=100 (function field). State 7 drives `reg_wr` with `wb_src`=01 (ALU result).
- R7: A branch uses state 8 and then returns to 0. In state 8, `alu_sel`=010 (subtract), `pc_src`=010 (branch target) and `pc_load` equals `alu_zero`.
- R8: A jump uses state 9 and then returns to 0. In state 9, `pc_src`=100 (jump target) and `pc_load`=1.
- R9: States 0, 3 and 5 keep their state and outputs while `mem_wait` is high. In every other state `mem_wait` has no effect on the state sequence or on the outputs.
- R10: Each strobe not listed for a state is 0. `pc_src`, `alu_sel` and `wb_src` never have more than one bit set, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_type | input | TYPE_W | Instruction class field from the instruction register |
| mem_wait | input | 1 | Memory not yet ready |
| alu_zero | input | 1 | ALU zero status |
| fsm_state | output | 4 | Current state code |
| pc_src | output | 3 | One-hot PC source: bit0 PC+1, bit1 branch target, bit2 jump target |
| pc_load | output | 1 | PC write enable |
| ir_latch | output | 1 | Instruction register capture |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address from computed address (1) or PC (0) |
| reg_rd | output | 1 | Register operand read |
| alu_sel | output | 3 | One-hot ALU op: bit0 add, bit1 subtract, bit2 function field |
| reg_wr | output | 1 | Register file write enable |
| wb_src | output | 2 | One-hot write-back source: bit0 ALU, bit1 memory |

## Verification
The assertions check the following properties on every cycle: fetch moves to decode once memory is ready, memory states hold while the wait flag is high, the load chain moves forward, unknown classes go back to fetch, the select groups stay one-hot, and read and write never overlap. Other behaviour can only be shown by the bench scenarios, because each needs a particular stimulus: the complete state trace of each class, branches taken and not taken, long waits in fetch and in the memory states, a wait flag held high outside memory states that must have no effect, and a reset applied partway through an instruction.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   localparam int STATE_BITS = 4;

   typedef enum logic [STATE_BITS-1:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_ADDR   = 4'd2,
      ST_MEMRD  = 4'd3,
      ST_LDWB   = 4'd4,
      ST_MEMWR  = 4'd5,
      ST_EXEC   = 4'd6,
      ST_ALUWB  = 4'd7,
      ST_BRANCH = 4'd8,
      ST_JUMP   = 4'd9
   } mc_state_e;

   // instruction class codes carried by the type field
   localparam int unsigned TY_ALU    = 0;
   localparam int unsigned TY_LOAD   = 1;
   localparam int unsigned TY_STORE  = 2;
   localparam int unsigned TY_BRANCH = 3;
   localparam int unsigned TY_JUMP   = 4;
   localparam int unsigned TY_MIN_W  = 3;

   localparam int PCSRC_W = 3;
   localparam int ALU_W   = 3;
   localparam int WB_W    = 2;

   typedef struct packed {
      logic [PCSRC_W-1:0] pc_src;
      logic               pc_load;
      logic               ir_latch;
      logic               mem_rd;
      logic               mem_wr;
      logic               addr_sel;
      logic               reg_rd;
      logic [ALU_W-1:0]   alu_sel;
      logic               reg_wr;
      logic [WB_W-1:0]    wb_src;
   } mc_ctrl_t;

   function automatic logic is_mem_state(input mc_state_e s);
      return (s == ST_FETCH) || (s == ST_MEMRD) || (s == ST_MEMWR);
   endfunction

endpackage

// File: rtl/mcc_state_reg.sv
module mcc_state_reg
   import mcc_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  mc_state_e nxt,
   output mc_state_e cur
);

   always_ff @(posedge clk) begin
      if (rst) cur <= ST_FETCH;
      else     cur <= nxt;
   end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
   import mcc_pkg::*;
#(
   parameter int TYPE_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  mc_state_e         cur,
   input  logic [TYPE_W-1:0] itype,
   input  logic              mem_wait,
   output mc_state_e         nxt
);

   localparam logic [TYPE_W-1:0] K_ALU    = TYPE_W'(TY_ALU);
   localparam logic [TYPE_W-1:0] K_LOAD   = TYPE_W'(TY_LOAD);
   localparam logic [TYPE_W-1:0] K_STORE  = TYPE_W'(TY_STORE);
   localparam logic [TYPE_W-1:0] K_BRANCH = TYPE_W'(TY_BRANCH);
   localparam logic [TYPE_W-1:0] K_JUMP   = TYPE_W'(TY_JUMP);

   mc_state_e fan_out;

   // class field picks the first state of the class chain
   always_comb begin
      unique case (itype)
         K_ALU:            fan_out = ST_EXEC;
         K_LOAD, K_STORE:  fan_out = ST_ADDR;
         K_BRANCH:         fan_out = ST_BRANCH;
         K_JUMP:           fan_out = ST_JUMP;
         default:          fan_out = ST_FETCH;
      endcase
   end

   always_comb begin
      nxt = ST_FETCH;
      case (cur)
         ST_FETCH:  nxt = mem_wait ? ST_FETCH : ST_DECODE;
         ST_DECODE: nxt = fan_out;
         ST_ADDR:   nxt = (itype == K_STORE) ? ST_MEMWR : ST_MEMRD;
         ST_MEMRD:  nxt = mem_wait ? ST_MEMRD : ST_LDWB;
         ST_MEMWR:  nxt = mem_wait ? ST_MEMWR : ST_FETCH;
         ST_EXEC:   nxt = ST_ALUWB;
         default:   nxt = ST_FETCH;
      endcase
   end

   assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
      (cur == ST_FETCH && !mem_wait) |=> (cur == ST_DECODE));

   assert_wait_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (is_mem_state(cur) && mem_wait) |=> $stable(cur));

   assert_unknown_type_R3: assert property (@(posedge clk) disable iff (rst)
      (cur == ST_DECODE && itype > K_JUMP) |=> (cur == ST_FETCH));

   assert_load_advance_R4: assert property (@(posedge clk) disable iff (rst)
      (cur == ST_MEMRD && !mem_wait) |=> (cur == ST_LDWB));

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
   import mcc_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  mc_state_e cur,
   input  logic      mem_wait,
   input  logic      alu_zero,
   output mc_ctrl_t  ctl
);

   localparam logic [PCSRC_W-1:0] PC_INC = PCSRC_W'(1);
   localparam logic [PCSRC_W-1:0] PC_BR  = PCSRC_W'(2);
   localparam logic [PCSRC_W-1:0] PC_JMP = PCSRC_W'(4);
   localparam logic [ALU_W-1:0]   OP_ADD = ALU_W'(1);
   localparam logic [ALU_W-1:0]   OP_SUB = ALU_W'(2);
   localparam logic [ALU_W-1:0]   OP_FN  = ALU_W'(4);
   localparam logic [WB_W-1:0]    WB_ALU = WB_W'(1);
   localparam logic [WB_W-1:0]    WB_MEM = WB_W'(2);

   always_comb begin
      ctl = '0;
      case (cur)
         ST_FETCH: begin
            ctl.mem_rd   = 1'b1;
            ctl.alu_sel  = OP_ADD;
            ctl.pc_src   = PC_INC;
            ctl.pc_load  = !mem_wait;
            ctl.ir_latch = !mem_wait;
         end
         ST_DECODE: ctl.reg_rd = 1'b1;
         ST_ADDR:   ctl.alu_sel = OP_ADD;
         ST_MEMRD: begin
            ctl.mem_rd   = 1'b1;
            ctl.addr_sel = 1'b1;
         end
         ST_LDWB: begin
            ctl.reg_wr = 1'b1;
            ctl.wb_src = WB_MEM;
         end
         ST_MEMWR: begin
            ctl.mem_wr   = 1'b1;
            ctl.addr_sel = 1'b1;
         end
         ST_EXEC:   ctl.alu_sel = OP_FN;
         ST_ALUWB: begin
            ctl.reg_wr = 1'b1;
            ctl.wb_src = WB_ALU;
         end
         ST_BRANCH: begin
            ctl.alu_sel = OP_SUB;
            ctl.pc_src  = PC_BR;
            ctl.pc_load = alu_zero;
         end
         ST_JUMP: begin
            ctl.pc_src  = PC_JMP;
            ctl.pc_load = 1'b1;
         end
         default: ctl = '0;
      endcase
   end

   assert_onehot_groups_R10: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ctl.pc_src) && $onehot0(ctl.alu_sel) && $onehot0(ctl.wb_src));

   assert_mem_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
      !(ctl.mem_rd && ctl.mem_wr));

   assert_irlatch_fetch_R2: assert property (@(posedge clk) disable iff (rst)
      ctl.ir_latch |-> (ctl.mem_rd && !ctl.addr_sel && ctl.pc_load));

   assert_regwr_source_R6: assert property (@(posedge clk) disable iff (rst)
      ctl.reg_wr |-> $onehot(ctl.wb_src));

endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
   import mcc_pkg::*;
#(
   parameter int TYPE_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TYPE_W-1:0] instr_type,
   input  logic              mem_wait,
   input  logic              alu_zero,
   output logic [3:0]        fsm_state,
   output logic [2:0]        pc_src,
   output logic              pc_load,
   output logic              ir_latch,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              addr_sel,
   output logic              reg_rd,
   output logic [2:0]        alu_sel,
   output logic              reg_wr,
   output logic [1:0]        wb_src
);

   generate
      if (TYPE_W < int'(TY_MIN_W)) begin : g_bad_type_w
         $error("mc_sequencer: TYPE_W too narrow for the class codes");
      end
      if (STATE_BITS != 4) begin : g_bad_state_w
         $error("mc_sequencer: state code must be four bits");
      end
   endgenerate

   mc_state_e cur_st;
   mc_state_e nxt_st;
   mc_ctrl_t  ctl;

   mcc_state_reg u_state (
      .clk (clk),
      .rst (rst),
      .nxt (nxt_st),
      .cur (cur_st)
   );

   mcc_next_state #(.TYPE_W(TYPE_W)) u_next (
      .clk      (clk),
      .rst      (rst),
      .cur      (cur_st),
      .itype    (instr_type),
      .mem_wait (mem_wait),
      .nxt      (nxt_st)
   );

   mcc_out_decode u_dec (
      .clk      (clk),
      .rst      (rst),
      .cur      (cur_st),
      .mem_wait (mem_wait),
      .alu_zero (alu_zero),
      .ctl      (ctl)
   );

   assign fsm_state = cur_st;
   assign pc_src    = ctl.pc_src;
   assign pc_load   = ctl.pc_load;
   assign ir_latch  = ctl.ir_latch;
   assign mem_rd    = ctl.mem_rd;
   assign mem_wr    = ctl.mem_wr;
   assign addr_sel  = ctl.addr_sel;
   assign reg_rd    = ctl.reg_rd;
   assign alu_sel   = ctl.alu_sel;
   assign reg_wr    = ctl.reg_wr;
   assign wb_src    = ctl.wb_src;

   assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
      (fsm_state == 4'd9) |-> (pc_load && pc_src == 3'b100));

   assert_store_return_R5: assert property (@(posedge clk) disable iff (rst)
      (fsm_state == 4'd5 && !mem_wait) |=> (fsm_state == 4'd0));

endmodule

// File: tb/mc_sequencer_bench.sv
module mc_sequencer_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] instr_type = 3'd0;
   logic       mem_wait = 1'b0;
   logic       alu_zero = 1'b0;
   logic [3:0] fsm_state;
   logic [2:0] pc_src;
   logic       pc_load, ir_latch, mem_rd, mem_wr, addr_sel, reg_rd;
   logic [2:0] alu_sel;
   logic       reg_wr;
   logic [1:0] wb_src;

   int vectors = 0;
   int errs    = 0;
   int cyc     = 0;
   int m_state = 0;

   always #5 clk = ~clk;

   mc_sequencer u_mc_sequencer (
      .clk(clk), .rst(rst), .instr_type(instr_type), .mem_wait(mem_wait),
      .alu_zero(alu_zero), .fsm_state(fsm_state), .pc_src(pc_src),
      .pc_load(pc_load), .ir_latch(ir_latch), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .addr_sel(addr_sel), .reg_rd(reg_rd), .alu_sel(alu_sel), .reg_wr(reg_wr),
      .wb_src(wb_src)
   );

   // reference sequence taken from the requirements
   function automatic int ref_next(int s, int ty, bit w);
      case (s)
         0: return w ? 0 : 1;
         1: case (ty)
               0: return 6;
               1, 2: return 2;
               3: return 8;
               4: return 9;
               default: return 0;
            endcase
         2: return (ty == 2) ? 5 : 3;
         3: return w ? 3 : 4;
         5: return w ? 5 : 0;
         6: return 7;
         default: return 0;
      endcase
   endfunction

   // {state, pc_src, pc_load, ir_latch, mem_rd, mem_wr, addr_sel, reg_rd, alu_sel, reg_wr, wb_src}
   function automatic logic [18:0] ref_out(int s, bit w, bit z);
      logic [2:0] ps, al;
      logic pl, ir, rd, wr, ad, rr, rw;
      logic [1:0] wb;
      {ps, al, pl, ir, rd, wr, ad, rr, rw, wb} = '0;
      case (s)
         0: begin rd = 1; al = 3'b001; ps = 3'b001; pl = !w; ir = !w; end
         1: rr = 1;
         2: al = 3'b001;
         3: begin rd = 1; ad = 1; end
         4: begin rw = 1; wb = 2'b10; end
         5: begin wr = 1; ad = 1; end
         6: al = 3'b100;
         7: begin rw = 1; wb = 2'b01; end
         8: begin al = 3'b010; ps = 3'b010; pl = z; end
         9: begin ps = 3'b100; pl = 1; end
         default: ;
      endcase
      return {4'(s), ps, pl, ir, rd, wr, ad, rr, al, rw, wb};
   endfunction

   function automatic string tag_of(int s, bit w);
      if (w && (s == 0 || s == 3 || s == 5)) return "R9";
      case (s)
         0: return "R2";
         1: return "R3";
         2, 3, 4: return "R4";
         5: return "R5";
         6, 7: return "R6";
         8: return "R7";
         default: return "R8";
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) m_state <= 0;
      else     m_state <= ref_next(m_state, int'(instr_type), mem_wait);
   end

   task automatic compare(input string tag);
      logic [18:0] got, exp;
      got = {fsm_state, pc_src, pc_load, ir_latch, mem_rd, mem_wr, addr_sel,
             reg_rd, alu_sel, reg_wr, wb_src};
      exp = ref_out(m_state, mem_wait, alu_zero);
      vectors++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s state=%0d actual=%h expected=%h", tag, m_state, got, exp);
      end
      vectors++;
      if (!($onehot0(pc_src) && $onehot0(alu_sel) && $onehot0(wb_src)) || (mem_rd && mem_wr)) begin
         errs++;
         $display("FAIL R10 groups actual=%b_%b_%b rd=%b wr=%b expected one-hot0, no rd+wr",
                  pc_src, alu_sel, wb_src, mem_rd, mem_wr);
      end
   endtask

   task automatic reset_cycles(input int n);
      rst = 1'b1;
      mem_wait = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1 compare("R1");
      end
      rst = 1'b0;
   endtask

   // runs one instruction from fetch back to fetch
   task automatic do_instr(input int ty, input int fw, input int mw, input bit z, input bit ign);
      bit left = 0;
      int f = fw;
      int m = mw;
      for (int k = 0; k < 200; k++) begin
         instr_type = 3'(ty);
         alu_zero   = z;
         if (m_state == 0) begin
            mem_wait = (f > 0);
            if (f > 0) f--;
         end else if (m_state == 3 || m_state == 5) begin
            mem_wait = (m > 0);
            if (m > 0) m--;
         end else begin
            mem_wait = ign; // R9: must have no effect here
         end
         #1 compare(tag_of(m_state, mem_wait));
         @(negedge clk);
         if (m_state != 0) left = 1;
         else if (left) return;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         errs++;
         $display("FAIL R1 watchdog expired actual=%0d cycles expected<50000", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end

   initial begin
      reset_cycles(3);
      do_instr(0, 0, 0, 0, 0);   // R6 ALU op
      do_instr(1, 0, 0, 0, 0);   // R4 load
      do_instr(2, 0, 0, 0, 0);   // R5 store
      do_instr(3, 0, 0, 1, 0);   // R7 taken
      do_instr(3, 0, 0, 0, 0);   // R7 not taken
      do_instr(4, 0, 0, 0, 0);   // R8 jump
      do_instr(1, 2, 3, 0, 0);   // R9 waits in fetch and read
      do_instr(2, 1, 4, 0, 0);   // R9 waits in write
      do_instr(5, 0, 0, 0, 0);   // R3 unknown codes
      do_instr(6, 0, 0, 0, 0);
      do_instr(7, 0, 0, 0, 0);
      do_instr(0, 0, 0, 0, 1);   // R9 wait ignored outside memory states
      do_instr(1, 0, 0, 1, 1);
      do_instr(3, 0, 0, 1, 1);
      do_instr(4, 1, 0, 1, 1);
      // R1: reset in the middle of a load that is waiting on memory
      instr_type = 3'd1;
      mem_wait = 1'b0;
      for (int i = 0; i < 3; i++) begin
         #1 compare("R4");
         @(negedge clk);
      end
      mem_wait = 1'b1;
      #1 compare("R9");
      reset_cycles(2);
      do_instr(2, 0, 1, 0, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

endmodule